// File: doc/BRIEF.md
# SPI Mode 0 Byte Transmitter

This block is a send-only SPI master for a display link. A client offers one byte at a time, together with a flag that says whether the byte is pixel or parameter data (flag high) or a command (flag low). The block accepts the pair on a valid/ready handshake and lowers chip select. It then clocks the byte out most significant bit first in SPI mode 0 and pulses `tx_done` for one cycle when it has finished.

The serial clock comes from a divider that counts system clock cycles. The divider runs all the time, but its count restarts when a byte is accepted. The serial timing of every byte therefore starts from a fixed point, however long the link was idle. The half period in system cycles is computed from two frequency parameters, and the default gives 1 MHz from 100 MHz. The data/command flag is held on its own pin for the whole byte.

Top module: `spi_byte_tx`

## Requirements
- R1: After reset, `spi_cs_n` is 1, `spi_sclk` is 0, `tx_ready` is 1 and `tx_done` is 0.
- R2: `spi_sclk` is low whenever `spi_cs_n` is high, so the serial clock idles low.
- R3: Each byte appears on `spi_mosi` as eight bits, bit 7 first and bit 0 last, sampled at the eight rising edges of `spi_sclk`.
- R4: `spi_mosi` never changes while `spi_sclk` is high. It changes only in the cycle where `spi_sclk` falls, or when a byte is loaded.
- R5: In the first cycle after a byte is accepted, `spi_cs_n` is low, `spi_sclk` is low and `spi_mosi` already carries bit 7.
- R6: Each half period of `spi_sclk` lasts H system cycles, where H = ceil(CLK_HZ / (2*SCLK_HZ)). Counting the accepting clock edge as cycle 0, the k-th rising edge (k = 0..7) occurs at cycle (2k+1)*H and the k-th falling edge at cycle (2k+2)*H. This holds whatever the idle time before the byte.
- R7: `spi_dc` equals the `tx_dc` captured at acceptance (1 = data, 0 = command) and stays stable while `spi_cs_n` is low.
- R8: `spi_cs_n` goes low at the accepting edge and stays low through cycle 16*H. It returns high one cycle after the last falling edge of `spi_sclk`.
- R9: `tx_done` is high in exactly one cycle per byte, cycle 16*H. `tx_ready` is high again in the following cycle.
- R10: While `tx_ready` is low, `tx_valid`, `tx_data` and `tx_dc` are ignored, and the byte in flight and its flag go out unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_valid | input | 1 | A byte is offered |
| tx_data | input | 8 | Byte to send |
| tx_dc | input | 1 | 1 = data byte, 0 = command byte |
| tx_ready | output | 1 | Idle; accepts a byte when `tx_valid` is high |
| tx_done | output | 1 | One-cycle pulse after the last bit |
| spi_sclk | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data, MSB first |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_dc | output | 1 | Data/command flag for the byte in flight |

## Verification
If the bit counter or the state register goes wrong, the frame length changes. `tx_done` then moves away from cycle 16*H, and `spi_cs_n` rises early or late, which shows up in the first affected byte. If the divider is not resynchronised, the first rising edge shifts from cycle H by an amount that depends on the idle gap, so random gaps expose it within a few bytes. A shifter that moves on the wrong edge, or that takes new input while busy, corrupts the bits or `spi_dc` of the byte in flight. The random and directed patterns catch this at that byte's rising edges.

// File: rtl/spi_tx_pkg.sv
package spi_tx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_FIN   = 2'd2
  } tx_state_e;

  // System cycles per half serial period, rounded up so the rate never exceeds target
  function automatic int half_cycles(input longint clk_hz, input longint sclk_hz);
    longint h;
    h = (clk_hz + 2 * sclk_hz - 1) / (2 * sclk_hz);
    if (h < 1) h = 1;
    return int'(h);
  endfunction

  // Width of a counter that must hold values 0..n-1
  function automatic int count_width(input int n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/spi_tx_clkdiv.sv
module spi_tx_clkdiv #(
  parameter int HALF = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic resync,
  output logic tick
);
  import spi_tx_pkg::*;

  localparam int CW = count_width(HALF);
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);

  logic [CW-1:0] cnt;

  assign tick = (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (resync) cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end

  // R6
  tick_after_resync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resync && HALF > 1) |=> !tick);

endmodule

// File: rtl/spi_tx_shifter.sv
module spi_tx_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              load_dc,
  input  logic              shift,
  output logic              mosi,
  output logic              dc
);

  logic [DATA_W-1:0] sreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg <= '0;
      dc   <= 1'b0;
    end else if (load) begin
      sreg <= load_data;
      dc   <= load_dc;
    end else if (shift) begin
      sreg <= {sreg[DATA_W-2:0], 1'b0};
    end
  end

  assign mosi = sreg[DATA_W-1];

  // R10
  no_load_while_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(load && shift));

endmodule

// File: rtl/spi_tx_ctrl.sv
module spi_tx_ctrl #(
  parameter int DATA_W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_valid,
  input  logic tick,
  output logic tx_ready,
  output logic load,
  output logic shift,
  output logic sclk,
  output logic cs_n,
  output logic done
);
  import spi_tx_pkg::*;

  localparam int BW = count_width(DATA_W);
  localparam logic [BW-1:0] LAST_BIT = BW'(DATA_W - 1);

  tx_state_e   state;
  logic [BW-1:0] bit_idx;
  logic        fall_evt;
  logic        rise_evt;
  logic        last_fall;

  assign rise_evt  = (state == ST_SHIFT) && tick && !sclk;
  assign fall_evt  = (state == ST_SHIFT) && tick && sclk;
  assign last_fall = fall_evt && (bit_idx == LAST_BIT);

  assign tx_ready = (state == ST_IDLE);
  assign load     = tx_ready && tx_valid;
  assign shift    = fall_evt && !last_fall;
  assign cs_n     = (state == ST_IDLE);
  assign done     = (state == ST_FIN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      sclk    <= 1'b0;
      bit_idx <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          sclk <= 1'b0;
          if (tx_valid) begin
            state   <= ST_SHIFT;
            bit_idx <= '0;
          end
        end
        ST_SHIFT: begin
          if (rise_evt) sclk <= 1'b1;
          if (fall_evt) begin
            sclk <= 1'b0;
            if (last_fall) state <= ST_FIN;
            else           bit_idx <= bit_idx + 1'b1;
          end
        end
        ST_FIN:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2
  sclk_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && tx_ready));

  // R8
  cs_fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> $past(load));

  // R8
  cs_rise_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> ($past(done) && !sclk));

endmodule

// File: rtl/spi_byte_tx.sv
module spi_byte_tx #(
  parameter longint CLK_HZ  = 100_000_000,
  parameter longint SCLK_HZ = 1_000_000,
  parameter int     DATA_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_valid,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_dc,
  output logic              tx_ready,
  output logic              tx_done,
  output logic              spi_sclk,
  output logic              spi_mosi,
  output logic              spi_cs_n,
  output logic              spi_dc
);
  import spi_tx_pkg::*;

  localparam int HALF = half_cycles(CLK_HZ, SCLK_HZ);

  logic load_w;
  logic shift_w;
  logic tick_w;

  spi_tx_clkdiv #(.HALF(HALF)) u_div (
    .clk    (clk),
    .rst_n  (rst_n),
    .resync (load_w),
    .tick   (tick_w)
  );

  spi_tx_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .tx_valid (tx_valid),
    .tick     (tick_w),
    .tx_ready (tx_ready),
    .load     (load_w),
    .shift    (shift_w),
    .sclk     (spi_sclk),
    .cs_n     (spi_cs_n),
    .done     (tx_done)
  );

  spi_tx_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load_w),
    .load_data (tx_data),
    .load_dc   (tx_dc),
    .shift     (shift_w),
    .mosi      (spi_mosi),
    .dc        (spi_dc)
  );

  // R4
  mosi_hold_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spi_sclk |-> $stable(spi_mosi));

  // R7
  dc_frame_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!spi_cs_n && $past(!spi_cs_n)) |-> $stable(spi_dc));

endmodule

// File: tb/sim_spi_byte_tx.sv
module sim_spi_byte_tx;

  localparam longint CLK_HZ  = 100_000_000;
  localparam longint SCLK_HZ = 1_000_000;
  // bench restatement of the half period: ceiling of clk / (2*sclk)
  localparam int H = int'(CLK_HZ / (2 * SCLK_HZ) + ((CLK_HZ % (2 * SCLK_HZ)) != 0 ? 1 : 0));
  localparam int FRAME = 16 * H;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tx_valid = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic       tx_dc = 1'b0;
  logic       tx_ready, tx_done, spi_sclk, spi_mosi, spi_cs_n, spi_dc;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  spi_byte_tx #(.CLK_HZ(CLK_HZ), .SCLK_HZ(SCLK_HZ), .DATA_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_data(tx_data), .tx_dc(tx_dc),
    .tx_ready(tx_ready), .tx_done(tx_done), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
    .spi_cs_n(spi_cs_n), .spi_dc(spi_dc)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int rise_cycle(input int k);
    return (2 * k + 1) * H;
  endfunction

  task automatic send(input logic [7:0] d, input logic dc, input int gap, input bit hold);
    logic [7:0] got;
    int  rises;
    bit  prev_s;
    bit  prev_m;
    for (int g = 0; g < gap; g++) begin
      @(negedge clk);
      chk(spi_sclk == 1'b0 || spi_cs_n == 1'b0, "R2", spi_sclk, 0);
    end
    chk(tx_ready == 1'b1, "R9", tx_ready, 1);
    tx_valid = 1'b1; tx_data = d; tx_dc = dc;
    @(negedge clk);
    if (hold) begin
      tx_data = ~d; tx_dc = ~dc;
    end else begin
      tx_valid = 1'b0;
    end
    // cycle 0: one edge after acceptance
    chk(spi_cs_n == 1'b0, "R8", spi_cs_n, 0);
    chk(spi_sclk == 1'b0 && spi_mosi == d[7], "R5", {spi_sclk, spi_mosi}, {1'b0, d[7]});
    chk(tx_ready == 1'b0, "R10", tx_ready, 0);
    got = 8'h00; rises = 0; prev_s = spi_sclk; prev_m = spi_mosi;
    for (int c = 1; c <= FRAME + 1; c++) begin
      if (hold && c == FRAME) tx_valid = 1'b0;
      @(negedge clk);
      if (c <= FRAME) begin
        if (spi_sclk && !prev_s) begin
          if (rises < 8) begin
            chk(c == rise_cycle(rises), "R6", c, rise_cycle(rises));
            got[7 - rises] = spi_mosi;
          end
          rises++;
        end
        if (spi_sclk && prev_s) chk(spi_mosi == prev_m, "R4", spi_mosi, prev_m);
        if (spi_dc != dc) chk(1'b0, "R7", spi_dc, dc);
        if (spi_cs_n != 1'b0) chk(1'b0, "R8", spi_cs_n, 0);
        if (tx_done != (c == FRAME)) chk(1'b0, "R9", c, FRAME);
        if (c < FRAME && tx_ready) chk(1'b0, "R10", tx_ready, 0);
      end else begin
        chk(spi_cs_n == 1'b1 && spi_sclk == 1'b0, "R8", {spi_cs_n, spi_sclk}, 2'b10);
        chk(tx_ready == 1'b1 && tx_done == 1'b0, "R9", {tx_ready, tx_done}, 2'b10);
      end
      prev_s = spi_sclk; prev_m = spi_mosi;
    end
    chk(rises == 8, "R3", rises, 8);
    chk(got == d, hold ? "R10" : "R3", got, d);
    chk(spi_dc == dc, "R7", spi_dc, dc);
  endtask

  initial begin
    repeat (200_000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h0D15_EA5E));
    repeat (4) @(negedge clk);
    // R1 reset state, held and released
    chk(spi_cs_n == 1'b1 && spi_sclk == 1'b0 && tx_ready == 1'b1 && tx_done == 1'b0,
        "R1", {spi_cs_n, spi_sclk, tx_ready, tx_done}, 4'b1010);
    rst_n = 1'b1;
    @(negedge clk);
    chk(spi_cs_n == 1'b1 && spi_sclk == 1'b0 && tx_ready == 1'b1 && tx_done == 1'b0,
        "R1", {spi_cs_n, spi_sclk, tx_ready, tx_done}, 4'b1010);
    // directed corners
    send(8'hA5, 1'b0, 0, 1'b0);
    send(8'h00, 1'b1, 0, 1'b0);
    send(8'hFF, 1'b0, 3, 1'b1);
    send(8'h80, 1'b1, 1, 1'b0);
    send(8'h01, 1'b0, H + 7, 1'b1);
    send(8'h5A, 1'b1, 2 * H - 1, 1'b0);
    // random mix, random idle gaps move the free-running divider phase (R6)
    for (int i = 0; i < 40; i++) begin
      send(8'($urandom), 1'($urandom), int'($urandom % (2 * H)), 1'($urandom));
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule